// File: doc/BRIEF.md
# Operand Forwarding Unit

This block picks where each of the two ALU operands of a five-stage in-order integer pipeline comes from. It compares the two source register numbers of the instruction now in the execute stage with the destination register numbers held in the two later pipeline registers. The later pipeline registers are the one after execute and the one after memory access. The block then drives one three-way select code per operand. A dependent instruction therefore takes a fresh result straight from a pipeline register and does not wait for write-back.

The unit is purely combinational. The ALU, the pipeline registers, the operand multiplexers and the load-use stall logic sit outside it. A loaded value is never ready in time for the instruction right behind the load, so the surrounding stall logic must hold that consumer back one cycle. After that cycle this unit forwards the value from the memory/write-back register. The register file writes in the first half of a cycle and reads in the second half. A producer three instructions ahead is therefore served by the register file and needs no forwarding.

Top module: `fwd_unit`

## Requirements
- R1: When no valid match exists for an operand, its select is 2'b00, meaning the register-file value.
- R2: When the execute/memory stage has its write enable set, its destination is nonzero and it equals the operand's source, the select is 2'b10.
- R3: When the memory/write-back stage has its write enable set, its destination is nonzero and it equals the source, and there is no valid execute/memory match, the select is 2'b01.
- R4: When both stages hold valid matches for the same source, the select is 2'b10, so the younger result wins.
- R5: A stage whose write enable is low has no effect on either select, even if its destination equals the source.
- R6: A destination of register 0 is never forwarded, even with the write enable set. This holds also when the source is register 0.
- R7: The select for operand A depends only on source A, and the select for operand B depends only on source B. Two different forwarding choices can be active at the same time.
- R8: The code 2'b11 is never driven on either select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a_idx | input | REG_AW | First source register number of the executing instruction |
| src_b_idx | input | REG_AW | Second source register number of the executing instruction |
| exm_dst_idx | input | REG_AW | Destination register held after the execute stage |
| exm_wr_en | input | 1 | Register-write enable held after the execute stage |
| mwb_dst_idx | input | REG_AW | Destination register held after the memory stage |
| mwb_wr_en | input | 1 | Register-write enable held after the memory stage |
| sel_a | output | 2 | Select code for operand A |
| sel_b | output | 2 | Select code for operand B |

## Verification
The bound checker tests every input combination as it appears. It checks the priority of the younger result, the fallback to the older stage, the register-file default when nothing validly matches, and the absence of the unused code. What the checker cannot show is that the two operand paths are separate. It also cannot show that a disabled or zero-numbered producer leaves a select untouched against a reference that was worked out independently. The bench's full sweep over a three-bit register space covers these: every pairing of sources, destinations and enables is compared with arithmetic expectations.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_MWB = 2'b01,
    FWD_EXM = 2'b10
  } fwd_sel_e;

  localparam int NUM_SRC = 2;

endpackage

// File: rtl/fwd_stage_match.sv
module fwd_stage_match #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src_idx,
  input  logic [REG_AW-1:0] dst_idx,
  input  logic              wr_en,
  output logic              hit
);

  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic dst_live;
  logic idx_eq;

  // A stage can only forward a value it will really write to a real register.
  assign dst_live = wr_en && (dst_idx != ZERO_REG);
  assign idx_eq   = (dst_idx == src_idx);
  assign hit      = dst_live && idx_eq;

endmodule

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
  import fwd_pkg::*;
(
  input  logic     hit_exm,
  input  logic     hit_mwb,
  output fwd_sel_e sel
);

  // The younger result, from the execute/memory register, is checked first.
  always_comb begin
    sel = FWD_RF;
    if (hit_exm) begin
      sel = FWD_EXM;
    end else if (hit_mwb) begin
      sel = FWD_MWB;
    end
  end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src_a_idx,
  input  logic [REG_AW-1:0] src_b_idx,
  input  logic [REG_AW-1:0] exm_dst_idx,
  input  logic              exm_wr_en,
  input  logic [REG_AW-1:0] mwb_dst_idx,
  input  logic              mwb_wr_en,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b
);

  logic [REG_AW-1:0] src_idx [NUM_SRC];
  logic              hit_exm [NUM_SRC];
  logic              hit_mwb [NUM_SRC];
  fwd_sel_e          sel_w   [NUM_SRC];

  assign src_idx[0] = src_a_idx;
  assign src_idx[1] = src_b_idx;

  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      fwd_stage_match #(.REG_AW(REG_AW)) u_exm_match (
        .src_idx (src_idx[g]),
        .dst_idx (exm_dst_idx),
        .wr_en   (exm_wr_en),
        .hit     (hit_exm[g])
      );

      fwd_stage_match #(.REG_AW(REG_AW)) u_mwb_match (
        .src_idx (src_idx[g]),
        .dst_idx (mwb_dst_idx),
        .wr_en   (mwb_wr_en),
        .hit     (hit_mwb[g])
      );

      fwd_operand_sel u_sel (
        .hit_exm (hit_exm[g]),
        .hit_mwb (hit_mwb[g]),
        .sel     (sel_w[g])
      );
    end
  endgenerate

  assign sel_a = sel_w[0];
  assign sel_b = sel_w[1];

endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int REG_AW = 5
) (
  input logic [REG_AW-1:0] src_a_idx,
  input logic [REG_AW-1:0] src_b_idx,
  input logic [REG_AW-1:0] exm_dst_idx,
  input logic              exm_wr_en,
  input logic [REG_AW-1:0] mwb_dst_idx,
  input logic              mwb_wr_en,
  input logic [1:0]        sel_a,
  input logic [1:0]        sel_b
);

  logic known;
  logic va_exm, va_mwb, vb_exm, vb_mwb;

  assign known = !$isunknown({src_a_idx, src_b_idx, exm_dst_idx, exm_wr_en,
                               mwb_dst_idx, mwb_wr_en, sel_a, sel_b});

  assign va_exm = exm_wr_en && (|exm_dst_idx) && (exm_dst_idx == src_a_idx);
  assign va_mwb = mwb_wr_en && (|mwb_dst_idx) && (mwb_dst_idx == src_a_idx);
  assign vb_exm = exm_wr_en && (|exm_dst_idx) && (exm_dst_idx == src_b_idx);
  assign vb_mwb = mwb_wr_en && (|mwb_dst_idx) && (mwb_dst_idx == src_b_idx);

  always_comb begin
    if (known) begin
      // R8
      p_no_code3_r8: assert ((sel_a != 2'b11) && (sel_b != 2'b11));
      // R2 and R4: the younger stage wins
      p_exm_first_a_r4: assert (!va_exm || sel_a == 2'b10);
      p_exm_first_b_r4: assert (!vb_exm || sel_b == 2'b10);
      // R3
      p_mwb_fallback_a_r3: assert (!(va_mwb && !va_exm) || sel_a == 2'b01);
      p_mwb_fallback_b_r3: assert (!(vb_mwb && !vb_exm) || sel_b == 2'b01);
      // R1, R5 and R6: no valid producer leaves the register file selected
      p_rf_default_a_r1: assert ((va_exm || va_mwb) || sel_a == 2'b00);
      p_rf_default_b_r1: assert ((vb_exm || vb_mwb) || sel_b == 2'b00);
    end
  end

endmodule

bind fwd_unit fwd_unit_chk #(.REG_AW(REG_AW)) u_chk (
  .src_a_idx   (src_a_idx),
  .src_b_idx   (src_b_idx),
  .exm_dst_idx (exm_dst_idx),
  .exm_wr_en   (exm_wr_en),
  .mwb_dst_idx (mwb_dst_idx),
  .mwb_wr_en   (mwb_wr_en),
  .sel_a       (sel_a),
  .sel_b       (sel_b)
);

// File: tb/fwd_unit_tb.sv
`timescale 1ns/1ps
module fwd_unit_tb;

  localparam int AW = 3;
  localparam int NR = 1 << AW;

  logic          clk;
  logic [AW-1:0] src_a, src_b, exm_dst, mwb_dst;
  logic          exm_en, mwb_en;
  logic [1:0]    sel_a, sel_b;

  int n_vec;
  int n_bad;
  bit done;

  fwd_unit #(.REG_AW(AW)) u_dut (
    .src_a_idx   (src_a),
    .src_b_idx   (src_b),
    .exm_dst_idx (exm_dst),
    .exm_wr_en   (exm_en),
    .mwb_dst_idx (mwb_dst),
    .mwb_wr_en   (mwb_en),
    .sel_a       (sel_a),
    .sel_b       (sel_b)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [1:0] ref_sel(input int s, input int ed, input bit ee,
                                         input int md, input bit me);
    if (ee && ed != 0 && ed == s) return 2'b10;
    if (me && md != 0 && md == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic string req_of(input int s, input int ed, input bit ee,
                                   input int md, input bit me);
    bool_chk: begin end
    if (ee && ed != 0 && ed == s) return (me && md == s) ? "R4" : "R2";
    if (me && md != 0 && md == s) return "R3";
    if ((ee && ed == 0 && s == 0) || (me && md == 0 && s == 0)) return "R6";
    if ((!ee && ed == s) || (!me && md == s)) return "R5";
    return "R1";
  endfunction

  task automatic apply(input int a, input int b, input int ed, input bit ee,
                       input int md, input bit me, input string tag);
    logic [1:0] ea, eb;
    @(posedge clk);
    #1;
    src_a = a[AW-1:0]; src_b = b[AW-1:0];
    exm_dst = ed[AW-1:0]; exm_en = ee;
    mwb_dst = md[AW-1:0]; mwb_en = me;
    @(negedge clk);
    ea = ref_sel(a, ed, ee, md, me);
    eb = ref_sel(b, ed, ee, md, me);
    n_vec++;
    if (sel_a !== ea) begin
      n_bad++;
      $display("FAIL %s%s operand A: got %b expected %b (a=%0d ed=%0d ee=%0b md=%0d me=%0b)",
               req_of(a, ed, ee, md, me), tag, sel_a, ea, a, ed, ee, md, me);
    end
    if (sel_b !== eb) begin
      n_bad++;
      $display("FAIL %s%s operand B: got %b expected %b (b=%0d ed=%0d ee=%0b md=%0d me=%0b)",
               req_of(b, ed, ee, md, me), tag, sel_b, eb, b, ed, ee, md, me);
    end
    // R8: the unused code never appears
    if (sel_a === 2'b11 || sel_b === 2'b11) begin
      n_bad++;
      $display("FAIL R8: got %b/%b expected neither 11", sel_a, sel_b);
    end
  endtask

  initial begin
    n_vec = 0; n_bad = 0; done = 1'b0;
    src_a = '0; src_b = '0; exm_dst = '0; mwb_dst = '0; exm_en = 1'b0; mwb_en = 1'b0;

    // Idle state: all zero with enables set, R6 and R1 give the register file
    apply(0, 0, 0, 1'b1, 0, 1'b1, " idle");
    // R7: operand A takes the younger stage while B takes the older one
    apply(3, 5, 3, 1'b1, 5, 1'b1, " R7 split");
    apply(5, 3, 3, 1'b1, 5, 1'b1, " R7 swap");
    // R4: both stages match one source
    apply(4, 4, 4, 1'b1, 4, 1'b1, " R4 both");
    // R5: matching destinations with enables low
    apply(6, 6, 6, 1'b0, 6, 1'b0, " R5 disabled");
    // R2: producer directly ahead forwarded at once
    apply(2, 1, 2, 1'b1, 7, 1'b0, " R2 back-to-back");

    // Full sweep over every input pattern
    for (int a = 0; a < NR; a++)
      for (int b = 0; b < NR; b++)
        for (int ed = 0; ed < NR; ed++)
          for (int ee = 0; ee < 2; ee++)
            for (int md = 0; md < NR; md++)
              for (int me = 0; me < 2; me++)
                apply(a, b, ed, ee[0], md, me[0], " sweep");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule